// File: doc/BRIEF.md
# Two-Channel Interval-Stream Pulse Generator

This block drives two digital outputs. Each output is shaped by its own stream of duration words. A channel that has been started takes one word and drives its output high for that many clock cycles. When that time runs out, it takes the next word, inverts the output and holds the new level for the new count. Words in even positions of a stream set high times and words in odd positions set low times. The high time, the low time and so the duty cycle can therefore change on every pulse.

Each channel has its own counter, level register and control state, so activity on one channel never moves an edge on the other. A global enable gates both channels. Each channel has a start and a stop strobe. Stop lets the interval in progress run to its end. Each channel also reports when its stream ran dry, and pulses a flag when a requested stop has taken effect.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset every output is low: `pulse_out`, `dur_ready`, `underrun` and `done`.
- R2: When `start` is sampled with `enable` high, an idle channel arms on that edge. On the next edge it takes the word at the head of its stream, provided one is valid. Its output is high from the cycle after that edge. In the armed state `dur_ready` is high.
- R3: Each word taken inverts the channel output, and the new level lasts exactly the word's count in cycles. The next word is taken in the final cycle of the current interval, so adjacent intervals join with no gap cycle.
- R4: A duration word of 0 holds its level for one cycle, the same as a word of 1.
- R5: If no word is valid in the final cycle of an interval, the channel goes idle with its output low and sets `underrun`. The flag stays set until the channel is started again; it clears on the edge that samples the new `start`.
- R6: A `stop` sampled while running lets the current interval finish. The output is then low from the next cycle. `done` is high for exactly that one cycle, and no further word is taken. A `stop` sampled while armed returns the channel to idle and pulses `done` on the next cycle.
- R7: The two channels are independent: starting, feeding, stopping or underrunning one channel does not change the waveform of the other.
- R8: While `enable` is low, `start` is ignored and `dur_ready` is low. Dropping `enable` forces every channel idle with its output low from the next cycle.
- R9: While a channel is inside an interval and not in its final cycle, its `dur_ready` is low, so a valid word is left in the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global arm for both channels |
| start | input | NCH | Per-channel start strobe |
| stop | input | NCH | Per-channel stop request |
| dur_valid | input | NCH | Per-channel duration word valid |
| dur_data | input | NCH*DUR_W | Duration words; channel c uses bits [c*DUR_W +: DUR_W] |
| dur_ready | output | NCH | Per-channel duration word accepted when high with valid |
| pulse_out | output | NCH | Per-channel pulse output |
| underrun | output | NCH | Per-channel sticky flag: the stream ran dry |
| done | output | NCH | Per-channel one-cycle flag: the requested stop completed |

## Verification
If `start` is driven in cycle s and the stream is already loaded, the first high level is sampled in cycle s+2, and each level after it lasts exactly the count its word gives. `dur_ready` is combinational, so it is seen in the cycle the word is taken, which is the final cycle of an interval. `done` and `underrun` appear in the cycle right after the final cycle, and a dropped enable shows as a low output one cycle later. The bench stores every output on the falling clock edge, indexed by cycle number. From the start cycle and the word list, it rebuilds the expected waveform with its own counting and compares the two cycle by cycle. It samples flags and ready at the cycle indices given above.

// File: rtl/ptg_pkg.sv
`timescale 1ns/1ps
package ptg_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;
endpackage

// File: rtl/ptg_interval_timer.sv
`timescale 1ns/1ps
module ptg_interval_timer #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  output logic             last
);
  // hold length of one interval: a zero word counts as one cycle
  function automatic logic [DUR_W-1:0] hold_len(input logic [DUR_W-1:0] d);
    return (d == '0) ? {{(DUR_W-1){1'b0}}, 1'b1} : d;
  endfunction

  localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

  logic [DUR_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (clr) begin
      remain <= '0;
    end else if (load) begin
      remain <= hold_len(load_val);
    end else if (remain != '0) begin
      remain <= remain - ONE;
    end
  end

  assign last = (remain == ONE);

  // R4: a zero word yields a one-cycle interval
  assert_zero_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr && load_val == '0) |=> last);

  // R3: a loaded interval is never empty
  assert_load_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (remain != '0));
endmodule

// File: rtl/ptg_chan_fsm.sv
`timescale 1ns/1ps
module ptg_chan_fsm
  import ptg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic stop,
  input  logic dur_valid,
  input  logic timer_last,
  output logic dur_ready,
  output logic take,
  output logic level,
  output logic underrun,
  output logic done
);
  ch_state_e st;
  logic      stop_req;

  // named internal events
  logic stop_pend;
  logic ev_expire;
  logic ev_take;
  logic ev_underrun;
  logic ev_finish;

  assign stop_pend   = stop_req | stop;
  assign ev_expire   = enable && (st == CH_RUN) && timer_last;
  assign dur_ready   = enable && (((st == CH_ARMED) && !stop) ||
                                  (ev_expire && !stop_pend));
  assign ev_take     = dur_ready && dur_valid;
  assign ev_finish   = ev_expire && stop_pend;
  assign ev_underrun = ev_expire && !stop_pend && !dur_valid;
  assign take        = ev_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CH_IDLE;
      stop_req <= 1'b0;
      level    <= 1'b0;
      underrun <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        st       <= CH_IDLE;
        stop_req <= 1'b0;
        level    <= 1'b0;
      end else begin
        unique case (st)
          CH_IDLE: begin
            if (start) begin
              st       <= CH_ARMED;
              underrun <= 1'b0;
              stop_req <= 1'b0;
            end
          end
          CH_ARMED: begin
            if (stop) begin
              st   <= CH_IDLE;
              done <= 1'b1;
            end else if (ev_take) begin
              st    <= CH_RUN;
              level <= 1'b1;
            end
          end
          CH_RUN: begin
            if (stop) stop_req <= 1'b1;
            if (ev_finish) begin
              st       <= CH_IDLE;
              level    <= 1'b0;
              done     <= 1'b1;
              stop_req <= 1'b0;
            end else if (ev_take) begin
              level <= ~level;
            end else if (ev_underrun) begin
              st       <= CH_IDLE;
              level    <= 1'b0;
              underrun <= 1'b1;
            end
          end
          default: st <= CH_IDLE;
        endcase
      end
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st != CH_RUN) |-> !level);

  assert_first_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_ARMED && ev_take) |=> (level && st == CH_RUN));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_RUN && ev_take) |=> (level != $past(level)));

  assert_underrun_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> (st == CH_IDLE && !level && underrun));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == CH_IDLE && !level));

  assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st == CH_IDLE && !level));

  assert_no_take_midinterval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_RUN && !timer_last) |-> !dur_ready);
endmodule

// File: rtl/ptg_channel.sv
`timescale 1ns/1ps
module ptg_channel #(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             stop,
  input  logic             dur_valid,
  input  logic [DUR_W-1:0] dur_data,
  output logic             dur_ready,
  output logic             pulse_out,
  output logic             underrun,
  output logic             done
);
  logic timer_last;
  logic take;

  ptg_interval_timer #(.DUR_W(DUR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!enable),
    .load     (take),
    .load_val (dur_data),
    .last     (timer_last)
  );

  ptg_chan_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start      (start),
    .stop       (stop),
    .dur_valid  (dur_valid),
    .timer_last (timer_last),
    .dur_ready  (dur_ready),
    .take       (take),
    .level      (pulse_out),
    .underrun   (underrun),
    .done       (done)
  );
endmodule

// File: rtl/pulse_train_gen.sv
`timescale 1ns/1ps
module pulse_train_gen #(
  parameter int NCH   = 2,
  parameter int DUR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NCH-1:0]       start,
  input  logic [NCH-1:0]       stop,
  input  logic [NCH-1:0]       dur_valid,
  input  logic [NCH*DUR_W-1:0] dur_data,
  output logic [NCH-1:0]       dur_ready,
  output logic [NCH-1:0]       pulse_out,
  output logic [NCH-1:0]       underrun,
  output logic [NCH-1:0]       done
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ptg_channel #(.DUR_W(DUR_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .start     (start[c]),
      .stop      (stop[c]),
      .dur_valid (dur_valid[c]),
      .dur_data  (dur_data[c*DUR_W +: DUR_W]),
      .dur_ready (dur_ready[c]),
      .pulse_out (pulse_out[c]),
      .underrun  (underrun[c]),
      .done      (done[c])
    );
  end

  // R1: no output is active right after reset is released
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pulse_out == '0 && done == '0 && underrun == '0));
endmodule

// File: tb/tb_pulse_train_gen.sv
`timescale 1ns/1ps
module tb_pulse_train_gen;
  localparam int NCH = 2;
  localparam int DW  = 32;
  localparam int TRL = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [NCH-1:0] start = '0, stop = '0, dur_valid = '0;
  logic [NCH*DW-1:0] dur_data = '0;
  logic [NCH-1:0] dur_ready, pulse_out, underrun, done;

  pulse_train_gen #(.NCH(NCH), .DUR_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .stop(stop),
    .dur_valid(dur_valid), .dur_data(dur_data), .dur_ready(dur_ready),
    .pulse_out(pulse_out), .underrun(underrun), .done(done));

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  int unsigned fq [NCH][$];
  logic [NCH-1:0] tr_out [TRL];
  logic [NCH-1:0] tr_done [TRL];
  logic [NCH-1:0] tr_rdy [TRL];

  task automatic refresh();
    for (int c = 0; c < NCH; c++) begin
      dur_valid[c] = (fq[c].size() != 0);
      dur_data[c*DW +: DW] = (fq[c].size() != 0) ? fq[c][0] : 32'd0;
    end
  endtask

  always @(posedge clk) begin
    logic [NCH-1:0] hs;
    hs = dur_valid & dur_ready;
    cyc++;
    for (int c = 0; c < NCH; c++) if (hs[c]) void'(fq[c].pop_front());
    #1 refresh();
  end

  always @(negedge clk) begin
    if (cyc < TRL) begin
      tr_out[cyc]  = pulse_out;
      tr_done[cyc] = done;
      tr_rdy[cyc]  = dur_ready;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // rebuild the expected waveform by counting down each word
  task automatic check_wave(int ch, int s, int unsigned d[$], string req);
    int idx = s + 2;
    bit lvl = 1'b1;
    int bad = 0, first_bad = -1;
    bit badv = 1'b0;
    if (tr_out[s+1][ch] !== 1'b0) begin bad++; first_bad = s+1; badv = tr_out[s+1][ch]; end
    foreach (d[i]) begin
      int n = (d[i] == 0) ? 1 : int'(d[i]);
      for (int k = 0; k < n; k++) begin
        if (tr_out[idx][ch] !== lvl) begin
          if (first_bad < 0) begin first_bad = idx; badv = tr_out[idx][ch]; end
          bad++;
        end
        idx++;
      end
      lvl = ~lvl;
    end
    for (int k = 0; k < 3; k++) begin
      if (tr_out[idx][ch] !== 1'b0) begin
        if (first_bad < 0) begin first_bad = idx; badv = tr_out[idx][ch]; end
        bad++;
      end
      idx++;
    end
    check(bad == 0, req, $sformatf("ch%0d waveform mismatch cycles (first at %0d, value %0d)",
          ch, first_bad, badv), bad, 0);
  endtask

  task automatic do_start(logic [NCH-1:0] m, output int s);
    @(negedge clk); start = m; s = cyc;
    @(negedge clk); start = '0;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_queues();
    for (int c = 0; c < NCH; c++) fq[c].delete();
    @(negedge clk); refresh();
  endtask

  task automatic t_reset();
    check(pulse_out == 0, "R1", "pulse_out after reset", pulse_out, 0);
    check(dur_ready == 0, "R1", "dur_ready after reset", dur_ready, 0);
    check(underrun == 0 && done == 0, "R1", "flags after reset", {underrun, done}, 0);
  endtask

  task automatic t_basic();
    int s;
    int unsigned d[$] = '{3, 5, 2, 4};
    fq[0] = d; @(negedge clk); refresh();
    do_start(2'b01, s);
    wait_cycles(3+5+2+4+6);
    check(tr_rdy[s+1][0] == 1'b1, "R2", "ready while armed", tr_rdy[s+1][0], 1);
    check(tr_out[s+1][0] == 1'b0 && tr_out[s+2][0] == 1'b1, "R2", "first high at start+2",
          tr_out[s+2][0], 1);
    check_wave(0, s, d, "R3");
    check(tr_rdy[s+3][0] == 1'b0, "R9", "ready mid-interval", tr_rdy[s+3][0], 0);
    check(tr_rdy[s+4][0] == 1'b1, "R3", "ready in final cycle", tr_rdy[s+4][0], 1);
    check(underrun[0] == 1'b1 && pulse_out[0] == 1'b0, "R5", "underrun after dry stream",
          underrun[0], 1);
    check(tr_out[s+17][1] == 1'b0 && underrun[1] == 1'b0, "R7", "ch1 untouched",
          {tr_out[s+17][1], underrun[1]}, 0);
  endtask

  task automatic t_zero();
    int s;
    int unsigned d[$] = '{0, 0, 1, 3};
    fq[0] = d; @(negedge clk); refresh();
    do_start(2'b01, s);
    check(underrun[0] == 1'b0, "R5", "underrun cleared by new start", underrun[0], 0);
    wait_cycles(12);
    check_wave(0, s, d, "R4");
  endtask

  task automatic t_stop();
    int s, nd;
    int unsigned d[$] = '{4, 4, 4, 4, 4, 4};
    int unsigned two[$] = '{4, 4};
    fq[0] = d; @(negedge clk); refresh();
    do_start(2'b01, s);
    wait_until(s + 6); stop[0] = 1'b1;
    @(negedge clk); stop[0] = 1'b0;
    wait_cycles(10);
    check_wave(0, s, two, "R6");
    check(tr_done[s+10][0] == 1'b1 && tr_done[s+9][0] == 1'b0, "R6", "done one cycle after final",
          tr_done[s+10][0], 1);
    nd = 0;
    for (int i = s; i < s + 18; i++) nd += tr_done[i][0];
    check(nd == 1, "R6", "done pulse count", nd, 1);
    check(fq[0].size() == 4, "R6", "words left after stop", fq[0].size(), 4);
    clear_queues();
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_indep();
    int s0, s1, tmp;
    int unsigned a[$] = '{4, 4, 4, 4};
    int unsigned a1[$] = '{4};
    int unsigned b[$] = '{3, 2, 5, 1, 2};
    fq[0] = a; fq[1] = b; @(negedge clk); refresh();
    do_start(2'b01, s0);
    s1 = cyc; start = 2'b10;
    @(negedge clk); start = '0;
    tmp = s0 + 3; wait_until(tmp); stop[0] = 1'b1;
    @(negedge clk); stop[0] = 1'b0;
    wait_cycles(20);
    check_wave(0, s0, a1, "R7");
    check_wave(1, s1, b, "R7");
    check(fq[0].size() == 3, "R6", "no word taken after stop", fq[0].size(), 3);
    check(underrun == 2'b10, "R7", "underrun only on ch1", underrun, 2);
    clear_queues();
  endtask

  task automatic t_enable();
    int s;
    enable = 1'b0;
    fq[0].push_back(5); @(negedge clk); refresh();
    do_start(2'b01, s);
    wait_cycles(4);
    check(pulse_out[0] == 1'b0 && dur_ready[0] == 1'b0, "R8", "start ignored while disabled",
          {pulse_out[0], dur_ready[0]}, 0);
    check(fq[0].size() == 1, "R8", "word kept while disabled", fq[0].size(), 1);
    enable = 1'b1;
    do_start(2'b01, s);
    wait_until(s + 4);
    check(pulse_out[0] == 1'b1, "R2", "running before disable", pulse_out[0], 1);
    enable = 1'b0;
    @(negedge clk);
    check(pulse_out[0] == 1'b0 && dur_ready[0] == 1'b0, "R8", "disable forces low",
          {pulse_out[0], dur_ready[0]}, 0);
    enable = 1'b1;
    clear_queues();
    do_start(2'b01, s);
    wait_until(s + 2); stop[0] = 1'b1;
    @(negedge clk); stop[0] = 1'b0;
    wait_cycles(2);
    check(tr_done[s+3][0] == 1'b1 && tr_done[s+2][0] == 1'b0, "R6", "stop while armed",
          tr_done[s+3][0], 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    refresh();
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    wait_cycles(2);
    t_basic();
    t_zero();
    t_stop();
    t_indep();
    t_enable();
    wait_cycles(5);
    finish_run();
  end
endmodule